// File: doc/BRIEF.md
# Cross-Batch Register Pull Tracker

One single thread of execution can be spread across several execution clusters. Each cluster takes a contiguous batch of the instruction stream, and batches are handed out in program order. This tracker sits in the cluster that holds the youngest batch. It keeps a record of which architectural registers the batch has produced for itself and which it has received from the cluster holding the previous batch. Values cross the cluster boundary only for true live-ins.

In demand mode, a source that reads a register the batch has neither produced nor received starts a single pull request to the older cluster. The source then reports not ready until the response has been recorded. A register that the batch has already written never leaves the cluster.

In full-copy mode, the start of the batch launches a sweep that requests every register in ascending index order. A busy flag stays high until all registers have been received. While the flag is high, no instruction is accepted.

Only the bookkeeping lives here: register values, renaming and execution belong to neighbouring logic.

Top module: `reg_pull_tracker`

## Requirements
- R1: After reset no register is available: a valid source reports not ready, no pull request is offered and the copy-busy flag is low.
- R2: A batch-start cycle clears the written and received records, so a register available before it reads as not ready afterwards (demand mode when copyMode is 0).
- R3: A source reports ready when it is not valid, or when its register was written by an accepted instruction of this batch, or when its register was received. An instruction is accepted in a cycle where instValid is 1 and every source is ready, and only then is its destination recorded.
- R4: A register written by an accepted instruction before any read of it is never requested from the older cluster.
- R5: A read of a register that is neither available nor in flight, by a valid instruction, produces exactly one request. A register that is waiting or in flight is not requested again, however many sources read it.
- R6: When several registers wait for a request, the lowest index is offered first.
- R7: An offered request keeps pullReqValid high and pullReqIdx unchanged until pullReqReady is 1.
- R8: A response for an in-flight register makes that register available from the next cycle. A response for a register that is not in flight is ignored.
- R9: A batch start with copyMode 1 raises copyBusy from the next cycle. It then requests registers 0 to NUM_REGS-1 in ascending order, one per accepted handshake. copyBusy falls once all registers have been received.
- R10: While copyBusy is high, every source reports not ready, no instruction is accepted and no demand request is raised.
- R11: Sources presented with instValid 0 raise no request and record no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| batchStart | input | 1 | A new batch begins in this cycle |
| copyMode | input | 1 | With batchStart: 1 selects a full copy, 0 selects demand pulls |
| instValid | input | 1 | An instruction is presented |
| srcValid | input | NUM_SRC | Per-source valid |
| srcIdx | input | NUM_SRC x IDX_W | Per-source register index |
| dstValid | input | 1 | Instruction writes a destination |
| dstIdx | input | IDX_W | Destination register index |
| srcReady | output | NUM_SRC | Per-source availability |
| pullReqValid | output | 1 | Request offered to the older cluster |
| pullReqIdx | output | IDX_W | Register requested |
| pullReqReady | input | 1 | Older cluster accepts the request |
| pullRspValid | input | 1 | A register value has arrived |
| pullRspIdx | input | IDX_W | Register that arrived |
| copyBusy | output | 1 | Full-copy sweep in progress |

## Verification
Demand mode is exercised with four kinds of read pattern. Two different missing registers show the lowest-first order and the per-register request. Both sources naming the same register, and an instruction re-presented while it waits, show that no duplicate request is raised. A write followed by a read shows the local path with no request. Reads with instValid low, and stray responses, show inputs that must leave no trace. A full-copy batch with a reader waiting separates the ascending sweep and the stall from demand behaviour. A held-off request with a lower-index register arriving behind it separates request holding from re-arbitration.

// File: rtl/reg_pull_pkg.sv
package reg_pull_pkg;

  typedef struct packed {
    logic clearAll;
    logic reqFire;
    logic copyActive;
  } pull_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } copy_state_e;

endpackage

// File: rtl/reg_pull_ctrl.sv
module reg_pull_ctrl
  import reg_pull_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                batchStart,
  input  logic                copyMode,
  input  logic                pullReqReady,
  input  logic [NUM_REGS-1:0] needVec,
  input  logic                allPulled,
  output logic                pullReqValid,
  output logic [IDX_W-1:0]    pullReqIdx,
  output logic                copyBusy,
  output pull_strobe_t        strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  copy_state_e      state;
  logic [IDX_W-1:0] copyPtr;
  logic             holdValid;
  logic [IDX_W-1:0] holdIdx;
  logic [IDX_W-1:0] lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (needVec[i]) lowIdx = IDX_W'(i);
    end
  end

  always_comb begin
    copyBusy     = (state != ST_IDLE);
    pullReqValid = 1'b0;
    pullReqIdx   = lowIdx;
    if (!batchStart) begin
      if (state == ST_ISSUE) begin
        pullReqValid = 1'b1;
        pullReqIdx   = copyPtr;
      end else if (state == ST_IDLE) begin
        if (holdValid) begin
          pullReqValid = 1'b1;
          pullReqIdx   = holdIdx;
        end else if (|needVec) begin
          pullReqValid = 1'b1;
        end
      end
    end
    strobe.clearAll   = batchStart;
    strobe.reqFire    = pullReqValid && pullReqReady;
    strobe.copyActive = copyBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      copyPtr   <= '0;
      holdValid <= 1'b0;
      holdIdx   <= '0;
    end else if (batchStart) begin
      state     <= copyMode ? ST_ISSUE : ST_IDLE;
      copyPtr   <= '0;
      holdValid <= 1'b0;
    end else begin
      case (state)
        ST_ISSUE: begin
          if (pullReqReady) begin
            if (copyPtr == LAST_IDX) state <= ST_WAIT;
            else copyPtr <= copyPtr + 1'b1;
          end
        end
        ST_WAIT: begin
          if (allPulled) state <= ST_IDLE;
        end
        default: begin
          holdValid <= pullReqValid && !pullReqReady;
          holdIdx   <= pullReqIdx;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pullReqValid && !pullReqReady && !batchStart |=>
      (batchStart || (pullReqValid && $stable(pullReqIdx)))); // R7

  AST_COPY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    batchStart && copyMode |=> copyBusy); // R9

endmodule

// File: rtl/reg_pull_dp.sv
module reg_pull_dp
  import reg_pull_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pull_strobe_t                  strobe,
  input  logic [IDX_W-1:0]              reqIdx,
  input  logic                          instValid,
  input  logic [NUM_SRC-1:0]            srcValid,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] srcIdx,
  input  logic                          dstValid,
  input  logic [IDX_W-1:0]              dstIdx,
  input  logic                          pullRspValid,
  input  logic [IDX_W-1:0]              pullRspIdx,
  output logic [NUM_SRC-1:0]            srcReady,
  output logic [NUM_REGS-1:0]           needVec,
  output logic                          allPulled
);

  logic [NUM_REGS-1:0] written, pulled, inFlight, needed;
  logic [NUM_REGS-1:0] avail, demandSet, reqMask, rspMask, dstMask, lowerMask;
  logic                fire;

  assign avail     = written | pulled;
  assign needVec   = needed;
  assign allPulled = &pulled;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcReady[s] = !strobe.clearAll && !strobe.copyActive &&
                         (!srcValid[s] || avail[srcIdx[s]]);
  end

  assign fire = instValid && (&srcReady);

  always_comb begin
    demandSet = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (instValid && srcValid[s] && !strobe.copyActive &&
          !avail[srcIdx[s]] && !inFlight[srcIdx[s]]) begin
        demandSet[srcIdx[s]] = 1'b1;
      end
    end
  end

  assign reqMask   = strobe.reqFire ? (NUM_REGS'(1) << reqIdx) : '0;
  assign rspMask   = pullRspValid ? ((NUM_REGS'(1) << pullRspIdx) & inFlight) : '0;
  assign dstMask   = (fire && dstValid) ? (NUM_REGS'(1) << dstIdx) : '0;
  assign lowerMask = (NUM_REGS'(1) << reqIdx) - NUM_REGS'(1);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      written  <= '0;
      pulled   <= '0;
      inFlight <= '0;
      needed   <= '0;
    end else begin
      written  <= written | dstMask;
      pulled   <= pulled | rspMask;
      inFlight <= (inFlight | reqMask) & ~rspMask;
      needed   <= (needed | demandSet) & ~reqMask;
    end
  end

  AST_NO_DUP_PULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reqFire |-> (!inFlight[reqIdx] && !pulled[reqIdx])); // R5

  AST_COPY_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reqFire && strobe.copyActive |->
      ((lowerMask & ~(inFlight | pulled)) == '0)); // R9

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copyActive && !strobe.clearAll |=> $stable(written)); // R10

endmodule

// File: rtl/reg_pull_tracker.sv
module reg_pull_tracker
  import reg_pull_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          batchStart,
  input  logic                          copyMode,
  input  logic                          instValid,
  input  logic [NUM_SRC-1:0]            srcValid,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] srcIdx,
  input  logic                          dstValid,
  input  logic [IDX_W-1:0]              dstIdx,
  output logic [NUM_SRC-1:0]            srcReady,
  output logic                          pullReqValid,
  output logic [IDX_W-1:0]              pullReqIdx,
  input  logic                          pullReqReady,
  input  logic                          pullRspValid,
  input  logic [IDX_W-1:0]              pullRspIdx,
  output logic                          copyBusy
);

  pull_strobe_t        strobe;
  logic [NUM_REGS-1:0] needVec;
  logic                allPulled;

  reg_pull_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .batchStart(batchStart), .copyMode(copyMode),
    .pullReqReady(pullReqReady), .needVec(needVec), .allPulled(allPulled),
    .pullReqValid(pullReqValid), .pullReqIdx(pullReqIdx),
    .copyBusy(copyBusy), .strobe(strobe)
  );

  reg_pull_dp #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIdx(pullReqIdx),
    .instValid(instValid), .srcValid(srcValid), .srcIdx(srcIdx),
    .dstValid(dstValid), .dstIdx(dstIdx), .pullRspValid(pullRspValid),
    .pullRspIdx(pullRspIdx), .srcReady(srcReady), .needVec(needVec),
    .allPulled(allPulled)
  );

endmodule

// File: tb/reg_pull_tracker_tb_top.sv
module reg_pull_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int NROW = 20;

  logic clk = 1'b0;
  logic rstN, batchStart, copyMode, instValid, dstValid;
  logic [1:0] srcValid;
  logic [1:0][3:0] srcIdx;
  logic [3:0] dstIdx, pullReqIdx, pullRspIdx;
  logic [1:0] srcReady;
  logic pullReqValid, pullReqReady, pullRspValid, copyBusy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_pull_tracker #(.NUM_REGS(NREG), .NUM_SRC(2)) dut_i (
    .clk(clk), .rstN(rstN), .batchStart(batchStart), .copyMode(copyMode),
    .instValid(instValid), .srcValid(srcValid), .srcIdx(srcIdx),
    .dstValid(dstValid), .dstIdx(dstIdx), .srcReady(srcReady),
    .pullReqValid(pullReqValid), .pullReqIdx(pullReqIdx),
    .pullReqReady(pullReqReady), .pullRspValid(pullRspValid),
    .pullRspIdx(pullRspIdx), .copyBusy(copyBusy)
  );

  typedef struct packed {
    logic       iv;
    logic       s0v;
    logic [3:0] s0;
    logic       s1v;
    logic [3:0] s1;
    logic       dv;
    logic [3:0] d;
    logic       rv;
    logic [3:0] ri;
    logic       er0;
    logic       er1;
    logic       eqv;
    logic [3:0] eqi;
  } vec_t;

  // Demand mode with pullReqReady held at 1; one row per cycle.
  localparam vec_t TBL [NROW] = '{
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b0,4'd0,1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b0,4'd0,1'b0,1'b0,1'b1,4'd3},
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b0,4'd0,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b1,4'd3,1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b1,4'd5,1'b1,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd3,1'b1,4'd5,1'b1,4'd7,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd7,1'b1,4'd3,1'b1,4'd3,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd7,1'b0,4'd9,1'b0,4'd0,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b0,1'b1,4'd9,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b0,4'd0,1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b0,4'd0,1'b0,1'b0,1'b1,4'd9},
    '{1'b1,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b0,4'd0,1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,4'd9,1'b1,4'd9,1'b1,4'd9,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b1,4'd12,1'b1,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd12,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd12,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,1'b1,4'd12},
    '{1'b1,1'b0,4'd0,1'b0,4'd0,1'b1,4'd6,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b1,1'b1,4'd6,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0},
    '{1'b0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b0,4'd0,1'b1,1'b1,1'b0,4'd0}
  };

  function automatic string rowTag(int i);
    case (i)
      1, 2, 16: return "R6";
      11:       return "R5";
      3, 4, 12: return "R8";
      8, 9:     return "R11";
      14, 15:   return "R8";
      17, 18, 19: return "R4";
      default:  return "R3";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic clearInst();
    instValid = 1'b0; srcValid = '0; srcIdx = '0; dstValid = 1'b0; dstIdx = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish();
  end

  initial begin
    int reqLog [NREG];
    int nReq;
    bit haveRsp;
    logic [3:0] rspI;
    bit orderOk;

    rstN = 1'b0; batchStart = 1'b0; copyMode = 1'b0; pullReqReady = 1'b1;
    pullRspValid = 1'b0; pullRspIdx = '0;
    clearInst();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    srcValid = 2'b01; srcIdx[0] = 4'd0;
    @(negedge clk);
    check("R1 srcReady", int'(srcReady[0]), 0);
    check("R1 pullReqValid", int'(pullReqValid), 0);
    check("R1 copyBusy", int'(copyBusy), 0);

    // Demand-mode batch and the vector table
    @(posedge clk); #1 batchStart = 1'b1; copyMode = 1'b0; clearInst();
    @(posedge clk); #1 batchStart = 1'b0;
    for (int i = 0; i < NROW; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      instValid = TBL[i].iv; srcValid = {TBL[i].s1v, TBL[i].s0v};
      srcIdx[0] = TBL[i].s0; srcIdx[1] = TBL[i].s1;
      dstValid = TBL[i].dv; dstIdx = TBL[i].d;
      pullRspValid = TBL[i].rv; pullRspIdx = TBL[i].ri;
      @(negedge clk);
      check({rowTag(i), " src0"}, int'(srcReady[0]), int'(TBL[i].er0));
      check({rowTag(i), " src1"}, int'(srcReady[1]), int'(TBL[i].er1));
      check({rowTag(i), " reqValid"}, int'(pullReqValid), int'(TBL[i].eqv));
      if (TBL[i].eqv) check({rowTag(i), " reqIdx"}, int'(pullReqIdx), int'(TBL[i].eqi));
    end

    // Full-copy batch with a waiting reader of register 2
    @(posedge clk); #1 clearInst(); pullRspValid = 1'b0;
    batchStart = 1'b1; copyMode = 1'b1;
    @(posedge clk); #1 batchStart = 1'b0; copyMode = 1'b0;
    instValid = 1'b1; srcValid = 2'b01; srcIdx[0] = 4'd2;
    nReq = 0; haveRsp = 1'b0; rspI = '0;
    @(negedge clk);
    check("R9 busy after start", int'(copyBusy), 1);
    for (int c = 0; c < 80; c++) begin
      if (!copyBusy) break;
      if (srcReady[0]) check("R10 ready while busy", 1, 0);
      if (pullReqValid && pullReqReady) begin
        if (nReq < NREG) reqLog[nReq] = int'(pullReqIdx);
        nReq++;
        haveRsp = 1'b1; rspI = pullReqIdx;
      end else begin
        haveRsp = 1'b0;
      end
      @(posedge clk); #1 pullRspValid = haveRsp; pullRspIdx = rspI;
      @(negedge clk);
    end
    @(posedge clk); #1 pullRspValid = 1'b0;
    @(negedge clk);
    check("R9 busy dropped", int'(copyBusy), 0);
    check("R10 request count", nReq, NREG);
    orderOk = (nReq == NREG);
    for (int k = 0; k < NREG; k++) if (orderOk && reqLog[k] != k) orderOk = 1'b0;
    check("R9 ascending order", int'(orderOk), 1);
    check("R9 copied reg ready", int'(srcReady[0]), 1);
    check("R10 no demand after copy", int'(pullReqValid), 0);

    // New demand batch: clear, then back-pressure
    @(posedge clk); #1 clearInst(); batchStart = 1'b1; pullReqReady = 1'b0;
    @(posedge clk); #1 batchStart = 1'b0; srcValid = 2'b01; srcIdx[0] = 4'd2;
    @(negedge clk);
    check("R2 cleared after start", int'(srcReady[0]), 0);
    @(posedge clk); #1 instValid = 1'b1; srcIdx[0] = 4'd4;
    @(negedge clk);
    check("R5 no request yet", int'(pullReqValid), 0);
    @(posedge clk); #1 srcValid = 2'b11; srcIdx[1] = 4'd1;
    @(negedge clk);
    check("R6 first offer idx", int'(pullReqIdx), 4);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      @(negedge clk);
      check("R7 held valid", int'(pullReqValid), 1);
      check("R7 held idx", int'(pullReqIdx), 4);
    end
    @(posedge clk); #1 pullReqReady = 1'b1;
    @(negedge clk);
    check("R7 accepted idx", int'(pullReqIdx), 4);
    @(posedge clk); #1;
    @(negedge clk);
    check("R6 next idx", int'(pullReqIdx), 1);
    @(posedge clk); #1 clearInst();
    @(negedge clk);
    check("R5 no more requests", int'(pullReqValid), 0);
    finish();
  end

endmodule